// File: doc/BRIEF.md
# Error Counter Overflow Interrupt Unit

The unit keeps eight saturating event counters. Each counter has its own width and is fed by a one-cycle error strobe from upstream line-monitoring logic. A counter can reach its all-ones value only once per count period. At that moment it produces an overflow edge. The edge is recorded in an 8-bit status register only if the matching enable bit is set at that moment. An edge that is masked is dropped and is never reported later.

A processor reads the status register through `sts_q` while pulsing `sts_rd`, and the read clears the register on that clock edge. A single level interrupt `irq` is raised while any status bit and its enable bit are both 1. Each counter has its own clear strobe, so it can be zeroed after its value has been collected. Clearing a counter also re-arms its overflow edge.

Top module: `err_ovf_irq`

## Requirements
- R1: Counter i counts the clock edges on which `err_stb[i]` is 1. The counters are packed into `cnt_q` from LSB upward: index 0 framing-bit errors (12 bits), 1 CRC errors (10), 2 line code violations (16), 3 far-end block errors (10), 4 test-pattern bit errors (12), 5 severely errored frames (2), 6 change of alignment (4 is not used; 2 bits), 7 out-of-frame (4 bits).
- R2: A counter at its all-ones value holds there. Further strobes neither wrap it nor produce another overflow edge.
- R3: When a strobe takes counter i from all-ones minus one to all-ones, and `ien_q[i]` is 1 before that edge, `sts_q[i]` is 1 after that edge.
- R4: An overflow edge that occurs while `ien_q[i]` is 0 is never recorded, even if the enable bit is set afterwards.
- R5: A status bit stays 1 until a clock edge with `sts_rd` = 1. On that edge the whole register clears, and `sts_q` shows the pre-clear value during the read cycle.
- R6: If an overflow edge for bit i and a read occur on the same clock edge, `sts_q[i]` is 1 after the edge, while the other bits clear.
- R7: `irq` is 1 exactly when (`sts_q` & `ien_q`) is nonzero.
- R8: `cnt_clr[i]` zeroes counter i on the next edge and takes priority over a strobe on the same edge. A cleared counter can produce a new overflow edge.
- R9: After reset, all counters, `sts_q`, `ien_q` and `irq` are 0.
- R10: `ien_we` = 1 loads `ien_wdata` into `ien_q` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_stb | input | 8 | One-cycle error strobes, one per counter |
| cnt_clr | input | 8 | Per-counter clear strobes |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| ien_q | output | 8 | Enable register contents |
| sts_rd | input | 1 | Status read strobe (clear on read) |
| sts_q | output | 8 | Overflow status register |
| irq | output | 1 | Interrupt request |
| cnt_q | output | 68 | Packed counter values, index 0 at LSB |

## Verification
The embedded assertions check the following on every cycle:
- a saturated counter holds its value (R2);
- a status bit rises only when its counter stands at full scale and its enable was set (R3, R4);
- a set bit survives until a read (R5);
- a read with no strobe on that bit leaves the bit clear (R5);
- `irq` never fires without a status bit set (R7).

Some behaviours span many cycles or interleaved events, and only the bench scenarios show them. These are: a masked overflow staying unreported after a later enable, a read colliding with a fresh edge, a clear re-arming the edge, and the 16-bit counter running through its full range. A random phase compares every output against a bench model on each cycle.

// File: rtl/err_ovf_irq.sv
module err_ovf_irq #(
  parameter int W_FE   = 12,
  parameter int W_CRC  = 10,
  parameter int W_LCV  = 16,
  parameter int W_FEBE = 10,
  parameter int W_BERR = 12,
  parameter int W_SEF  = 2,
  parameter int W_COFA = 2,
  parameter int W_OOF  = 4,
  localparam int SUMW  = W_FE + W_CRC + W_LCV + W_FEBE + W_BERR + W_SEF + W_COFA + W_OOF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      err_stb,
  input  logic [7:0]      cnt_clr,
  input  logic            ien_we,
  input  logic [7:0]      ien_wdata,
  output logic [7:0]      ien_q,
  input  logic            sts_rd,
  output logic [7:0]      sts_q,
  output logic            irq,
  output logic [SUMW-1:0] cnt_q
);

  function automatic int cw(input int i);
    case (i)
      0: return W_FE;
      1: return W_CRC;
      2: return W_LCV;
      3: return W_FEBE;
      4: return W_BERR;
      5: return W_SEF;
      6: return W_COFA;
      default: return W_OOF;
    endcase
  endfunction

  function automatic int co(input int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += cw(k);
    return s;
  endfunction

  logic [7:0] sts_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~{8{sts_rd}}) | sts_set;

  assign irq = |(sts_q & ien_q);

  for (genvar i = 0; i < 8; i++) begin : g_ctr
    localparam int W = cw(i);
    localparam logic [W-1:0] MAX = '1;
    localparam logic [W-1:0] PRE = {{(W-1){1'b1}}, 1'b0};
    logic [W-1:0] cnt;
    logic         full;

    assign full = (cnt == MAX);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cnt <= '0;
      else if (cnt_clr[i])            cnt <= '0;
      else if (err_stb[i] && !full)   cnt <= cnt + 1'b1;

    assign sts_set[i] = err_stb[i] & ~cnt_clr[i] & (cnt == PRE) & ien_q[i];
    assign cnt_q[co(i) +: W] = cnt;

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      full && !cnt_clr[i] |=> cnt == MAX);  // R2
    AST_SET_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[i]) |-> cnt == MAX);  // R3
    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[i]) |-> $past(ien_q[i]));  // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sts_q[i] && !sts_rd |=> sts_q[i]);  // R5
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sts_rd && !err_stb[i] |=> !sts_q[i]);  // R5
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr[i] |=> cnt == '0);  // R8
  end

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_q != 8'h00);  // R7
  AST_IEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |=> ien_q == $past(ien_wdata));  // R10

endmodule

// File: tb/test_err_ovf_irq.sv
module test_err_ovf_irq;
  localparam int BW[8] = '{12, 10, 16, 10, 12, 2, 2, 4};
  localparam int SUMW = 68;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] err_stb = '0, cnt_clr = '0, ien_wdata = '0;
  logic ien_we = 1'b0, sts_rd = 1'b0;
  logic [7:0] ien_q, sts_q;
  logic irq;
  logic [SUMW-1:0] cnt_q;

  int unsigned m_cnt[8];
  logic [7:0] m_sts, m_ien;
  int vec = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  err_ovf_irq i_err_ovf_irq (
    .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .cnt_clr(cnt_clr),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ien_q(ien_q),
    .sts_rd(sts_rd), .sts_q(sts_q), .irq(irq), .cnt_q(cnt_q)
  );

  function automatic int off(input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += BW[k];
    return s;
  endfunction

  function automatic int unsigned cmax(input int i);
    return (32'd1 << BW[i]) - 1;
  endfunction

  function automatic int unsigned field(input int i);
    return int'((cnt_q >> off(i)) & SUMW'(cmax(i)));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 8; i++)
      chk(field(i) == m_cnt[i], $sformatf("R1 R2 R8 cnt[%0d]", i), field(i), m_cnt[i]);
    chk(sts_q == m_sts, "R3 R4 R5 R6 sts", sts_q, m_sts);
    chk(irq == |(m_sts & m_ien), "R7 irq", irq, |(m_sts & m_ien));
    chk(ien_q == m_ien, "R10 ien", ien_q, m_ien);
  endtask

  task automatic cyc(input logic [7:0] s, input logic [7:0] c, input logic rd,
                     input logic we, input logic [7:0] wd);
    logic [7:0] set;
    err_stb = s; cnt_clr = c; sts_rd = rd; ien_we = we; ien_wdata = wd;
    set = '0;
    for (int i = 0; i < 8; i++) begin
      if (s[i] && !c[i] && m_cnt[i] == cmax(i) - 1 && m_ien[i]) set[i] = 1'b1;
      if (c[i]) m_cnt[i] = 0;
      else if (s[i] && m_cnt[i] != cmax(i)) m_cnt[i]++;
    end
    m_sts = (rd ? 8'h00 : m_sts) | set;
    if (we) m_ien = wd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    m_sts = '0; m_ien = '0;
    repeat (3) @(negedge clk);
    compare_all();  // R9 reset state
    chk(irq == 1'b0 && sts_q == 8'h00, "R9 reset", {irq, sts_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(8'h00, 8'h00, 0, 1, 8'hBF);                     // R10 bit6 masked
    repeat (5) cyc(8'h40, 8'h00, 0, 0, 8'h00);          // R4 masked overflow
    cyc(8'h00, 8'h00, 0, 1, 8'hFF);
    repeat (3) cyc(8'h40, 8'h00, 0, 0, 8'h00);          // R2 no second edge
    chk(sts_q[6] == 1'b0 && irq == 1'b0, "R4 masked edge stays unreported", sts_q, 0);

    repeat (15) cyc(8'h80, 8'h00, 0, 0, 8'h00);         // R3 4-bit counter
    chk(sts_q == 8'h80 && irq, "R3 overflow latched", sts_q, 8'h80);
    repeat (2) cyc(8'h20, 8'h00, 0, 0, 8'h00);
    cyc(8'h20, 8'h00, 1, 0, 8'h00);                     // R6 read with edge
    chk(sts_q == 8'h20, "R6 edge wins over read-clear", sts_q, 8'h20);
    cyc(8'h00, 8'h00, 0, 1, 8'hDF);                     // R7 mask after set
    chk(irq == 1'b0 && sts_q == 8'h20, "R7 irq drops with enable", {irq, sts_q}, 8'h20);
    cyc(8'h00, 8'h00, 1, 1, 8'hFF);                     // R5 clear on read
    chk(sts_q == 8'h00, "R5 read clears", sts_q, 0);

    cyc(8'h40, 8'h40, 0, 0, 8'h00);                     // R8 clear beats strobe
    chk(field(6) == 0, "R8 clear priority", field(6), 0);
    repeat (3) cyc(8'h40, 8'h00, 0, 0, 8'h00);
    chk(sts_q == 8'h40, "R8 re-armed edge", sts_q, 8'h40);
    cyc(8'h00, 8'h00, 1, 0, 8'h00);

    for (int n = 0; n < 65536; n++) cyc(8'h04, 8'h00, 0, 0, 8'h00);  // R1 R2 16-bit
    chk(field(2) == 65535 && sts_q == 8'h04, "R1 16-bit full range", field(2), 65535);
    cyc(8'hFF, 8'hFF, 1, 0, 8'h00);

    for (int n = 0; n < 30000; n++) begin
      logic [7:0] c;
      c = '0;
      for (int i = 0; i < 8; i++) if ($urandom_range(4095) == 0) c[i] = 1'b1;
      cyc(8'($urandom) & 8'($urandom), c, $urandom_range(15) == 0,
          $urandom_range(63) == 0, 8'($urandom) | 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule